// File: doc/BRIEF.md
# Descriptor List Fetch Unit

This block walks a descriptor list held in memory and feeds its entries, one by one, to a downstream access engine. After a start pulse it reads a single 64-bit count word at the list base address. It then reads that many descriptors, each nine 64-bit words long and packed back to back behind the count. Each descriptor carries the address of the first element and four (stride, size) pairs, ordered from the innermost loop dimension to the outermost.

Reads go through a simple request/response port that is always 64 bits wide, whatever the element width of the engine. There is never more than one read in flight. A descriptor that has been fully collected is offered with a valid/ready handshake. The unit then stays idle until the engine reports that the access described by that entry has finished. Only then does it fetch the next entry. When the last access completes, the unit raises a one-cycle done pulse and returns to idle.

Top module: `dlist_fetch`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `mem_req`, `desc_valid` and `done` are low. A reset in the middle of a list abandons that list.
- R2: A `start` pulse while idle latches `list_base`. The first read request that follows targets word address `list_base`, which holds the descriptor count.
- R3: A `start` pulse while a list is in progress is ignored. The addresses fetched and the descriptors offered are those of the list already running.
- R4: For descriptor k (counted from 0) and word i (0 to 8), the read address is `list_base + 1 + 9*k + i`. Each word is read exactly once, in increasing address order.
- R5: At most one read is outstanding. A new request is issued only after `mem_rvalid` has returned the previous word, and any response delay of one cycle or more works.
- R6: Descriptor word 0 appears on `desc_base`. Word 2d+1 appears on `desc_stride[64*d +: 64]` and word 2d+2 on `desc_size[64*d +: 64]`, for d = 0 (innermost) to 3 (outermost).
- R7: Once raised, `desc_valid` stays high with all descriptor outputs unchanged until a cycle in which `desc_ready` is high.
- R8: After a descriptor is accepted, no read is issued until `access_done` is seen. `access_done` has no effect while a descriptor is still being offered.
- R9: For a count of N > 0, exactly N descriptors are offered. `done` is high for exactly one cycle, in the cycle after the `access_done` of the last descriptor.
- R10: A count of zero raises `done` for one cycle, the cycle after the count word returns. No descriptor is offered and no further read is made.
- R11: Only the low CNT_W bits (default 32) of the count word form the count; the upper bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin walking a list (used only when idle) |
| list_base | input | AW | Word address of the count word |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | AW | Word address of the read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Read data |
| desc_valid | output | 1 | Descriptor offered |
| desc_ready | input | 1 | Engine accepts the descriptor |
| desc_base | output | 64 | First-element address |
| desc_stride | output | 256 | Four strides, innermost in the low 64 bits |
| desc_size | output | 256 | Four sizes, innermost in the low 64 bits |
| access_done | input | 1 | Engine finished the current access |
| done | output | 1 | One-cycle pulse when the list is exhausted |

## Verification
The bench targets these corner cases:
- **Zero count.** A unit that enters the fetch loop anyway would read past the count word or offer a descriptor of stale data.
- **Count with upper bits set.** A unit that uses the full word would hang or offer far too many descriptors.
- **Extra start while busy.** A unit that re-latches the base would jump to another list.
- **access_done before acceptance.** A unit that honours it would skip ahead and fetch while a descriptor is still on offer.
- **Response latency and ready delay.** Both are varied, so a unit that assumes a fixed latency or drops a held descriptor would return wrong words or change the fields early.
- **Pacing.** Read counts are checked at every descriptor boundary, so a unit that prefetches the next entry is exposed.

// File: rtl/dlist_pkg.sv
package dlist_pkg;
  localparam int unsigned WORD_W     = 64;
  localparam int unsigned DESC_WORDS = 9;
  localparam int unsigned NDIM       = 4;
  localparam int unsigned IDX_W      = $clog2(DESC_WORDS);

  typedef enum logic [2:0] {
    ST_IDLE, ST_CNT_REQ, ST_CNT_WAIT, ST_WRD_REQ, ST_WRD_WAIT, ST_OFFER, ST_RUN
  } fsm_e;
endpackage

// File: rtl/dlist_addr.sv
module dlist_addr
  import dlist_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             base_ld,
  input  logic [AW-1:0]    base_in,
  input  logic             ptr_inc,
  input  logic             sel_cnt,
  output logic [AW-1:0]    mem_addr,
  output logic [IDX_W-1:0] word_idx,
  output logic             last_word
);
  logic [AW-1:0]    base_q, base_d, ptr_q, ptr_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    base_d = base_q;
    ptr_d  = ptr_q;
    idx_d  = idx_q;
    if (base_ld) begin
      base_d = base_in;
      ptr_d  = base_in + AW'(1);
      idx_d  = '0;
    end else if (ptr_inc) begin
      ptr_d = ptr_q + AW'(1);
      idx_d = last_word ? '0 : idx_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      ptr_q  <= '0;
      idx_q  <= '0;
    end else if (base_ld || ptr_inc) begin
      base_q <= base_d;
      ptr_q  <= ptr_d;
      idx_q  <= idx_d;
    end
  end

  assign last_word = (idx_q == IDX_W'(DESC_WORDS - 1));
  assign word_idx  = idx_q;
  assign mem_addr  = sel_cnt ? base_q : ptr_q;

  // Word index is advanced by the pointer logic; the capture side relies on it staying in range
  assert_idx_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q < IDX_W'(DESC_WORDS));
endmodule

// File: rtl/dlist_regs.sv
module dlist_regs
  import dlist_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           we,
  input  logic [IDX_W-1:0]               idx,
  input  logic [WORD_W-1:0]              wdata,
  output logic [DESC_WORDS*WORD_W-1:0]   words
);
  for (genvar g = 0; g < DESC_WORDS; g++) begin : g_word
    logic [WORD_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else if (we && (idx == IDX_W'(g))) q <= wdata;
    end
    assign words[g*WORD_W +: WORD_W] = q;
  end
endmodule

// File: rtl/dlist_ctrl.sv
module dlist_ctrl
  import dlist_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             mem_rvalid,
  input  logic [CNT_W-1:0] cnt_word,
  input  logic             last_word,
  input  logic             desc_ready,
  input  logic             access_done,
  output logic             mem_req,
  output logic             sel_cnt,
  output logic             base_ld,
  output logic             ptr_inc,
  output logic             word_we,
  output logic             desc_valid,
  output logic             done
);
  fsm_e             state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, k_q, k_d;
  logic             done_q, done_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    k_d     = k_q;
    done_d  = 1'b0;
    mem_req = 1'b0;
    sel_cnt = 1'b0;
    base_ld = 1'b0;
    ptr_inc = 1'b0;
    word_we = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start) begin
        base_ld = 1'b1;
        state_d = ST_CNT_REQ;
      end
      ST_CNT_REQ: begin
        mem_req = 1'b1;
        sel_cnt = 1'b1;
        state_d = ST_CNT_WAIT;
      end
      ST_CNT_WAIT: begin
        sel_cnt = 1'b1;
        if (mem_rvalid) begin
          cnt_d = cnt_word;
          k_d   = '0;
          if (cnt_word == '0) begin
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end else begin
            state_d = ST_WRD_REQ;
          end
        end
      end
      ST_WRD_REQ: begin
        mem_req = 1'b1;
        state_d = ST_WRD_WAIT;
      end
      ST_WRD_WAIT: if (mem_rvalid) begin
        word_we = 1'b1;
        ptr_inc = 1'b1;
        state_d = last_word ? ST_OFFER : ST_WRD_REQ;
      end
      ST_OFFER: if (desc_ready) state_d = ST_RUN;
      ST_RUN: if (access_done) begin
        if (k_q == cnt_q - CNT_W'(1)) begin
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          k_d     = k_q + CNT_W'(1);
          state_d = ST_WRD_REQ;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      k_q     <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      k_q     <= k_d;
      done_q  <= done_d;
    end
  end

  assign desc_valid = (state_q == ST_OFFER);
  assign done       = done_q;

  // The descriptor index never passes the count while a list is active
  assert_k_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_OFFER) |-> (k_q < cnt_q));
endmodule

// File: rtl/dlist_fetch.sv
module dlist_fetch
  import dlist_pkg::*;
#(
  parameter int unsigned AW    = 32,
  parameter int unsigned CNT_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [AW-1:0]          list_base,
  output logic                   mem_req,
  output logic [AW-1:0]          mem_addr,
  input  logic                   mem_rvalid,
  input  logic [63:0]            mem_rdata,
  output logic                   desc_valid,
  input  logic                   desc_ready,
  output logic [63:0]            desc_base,
  output logic [NDIM*64-1:0]     desc_stride,
  output logic [NDIM*64-1:0]     desc_size,
  input  logic                   access_done,
  output logic                   done
);
  logic                          sel_cnt, base_ld, ptr_inc, word_we, last_word;
  logic [IDX_W-1:0]              word_idx;
  logic [DESC_WORDS*WORD_W-1:0]  words;

  dlist_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .mem_rvalid(mem_rvalid),
    .cnt_word(mem_rdata[CNT_W-1:0]), .last_word(last_word),
    .desc_ready(desc_ready), .access_done(access_done), .mem_req(mem_req),
    .sel_cnt(sel_cnt), .base_ld(base_ld), .ptr_inc(ptr_inc), .word_we(word_we),
    .desc_valid(desc_valid), .done(done)
  );

  dlist_addr #(.AW(AW)) u_addr (
    .clk(clk), .rst_n(rst_n), .base_ld(base_ld), .base_in(list_base),
    .ptr_inc(ptr_inc), .sel_cnt(sel_cnt), .mem_addr(mem_addr),
    .word_idx(word_idx), .last_word(last_word)
  );

  dlist_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(word_we), .idx(word_idx),
    .wdata(mem_rdata), .words(words)
  );

  assign desc_base = words[0 +: WORD_W];
  for (genvar d = 0; d < NDIM; d++) begin : g_dim
    assign desc_stride[d*WORD_W +: WORD_W] = words[(2*d+1)*WORD_W +: WORD_W];
    assign desc_size[d*WORD_W +: WORD_W]   = words[(2*d+2)*WORD_W +: WORD_W];
  end

  // Checker state: outstanding read and address history
  logic          pend_q, have_prev_q;
  logic [AW-1:0] prev_q, lbase_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      have_prev_q <= 1'b0;
      prev_q      <= '0;
      lbase_q     <= '0;
    end else begin
      if (mem_req) pend_q <= 1'b1;
      else if (mem_rvalid) pend_q <= 1'b0;
      if (base_ld) begin
        have_prev_q <= 1'b0;
        lbase_q     <= list_base;
      end else if (mem_req) begin
        have_prev_q <= 1'b1;
        prev_q      <= mem_addr;
      end
    end
  end

  assert_single_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !pend_q);
  assert_first_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !have_prev_q) |-> (mem_addr == lbase_q));
  assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && have_prev_q) |-> (mem_addr == prev_q + AW'(1)));
  assert_offer_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_valid && !desc_ready) |=> (desc_valid && $stable(desc_base)
      && $stable(desc_stride) && $stable(desc_size)));
  assert_quiet_offer_R8: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid |-> !mem_req);
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

// File: tb/sim_dlist_fetch.sv
module sim_dlist_fetch;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [31:0]  list_base = '0;
  logic         mem_req;
  logic [31:0]  mem_addr;
  logic         mem_rvalid = 1'b0;
  logic [63:0]  mem_rdata = '0;
  logic         desc_valid;
  logic         desc_ready = 1'b0;
  logic [63:0]  desc_base;
  logic [255:0] desc_stride, desc_size;
  logic         access_done = 1'b0;
  logic         done;

  always #10 clk = ~clk;

  dlist_fetch u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .list_base(list_base),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .desc_valid(desc_valid), .desc_ready(desc_ready),
    .desc_base(desc_base), .desc_stride(desc_stride), .desc_size(desc_size),
    .access_done(access_done), .done(done)
  );

  int tests = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Memory model: one pending read, response after lat cycles
  logic [63:0] mem [256];
  int          lat = 1;
  logic        mpend = 1'b0;
  int          mcnt = 0;
  logic [7:0]  maddr = '0;
  int          req_idx = 0;
  logic [31:0] req_log [64];

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (mem_req) begin
      mpend <= 1'b1;
      mcnt  <= lat - 1;
      maddr <= mem_addr[7:0];
      if (req_idx < 64) req_log[req_idx] = mem_addr;
      req_idx = req_idx + 1;
    end else if (mpend) begin
      if (mcnt == 0) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem[maddr];
        mpend      <= 1'b0;
      end else begin
        mcnt <= mcnt - 1;
      end
    end
  end

  function automatic logic [63:0] pat(input int a);
    return {32'hC0DE_0000 | 32'(a), ~32'(a)};
  endfunction

  typedef struct packed {
    logic [7:0]  base;
    logic [63:0] cnt;
    logic [3:0]  lat;
    logic [3:0]  rdly;
    logic        restart;
    logic        early;
  } vec_t;

  localparam vec_t VEC [5] = '{
    '{base: 8'd0,   cnt: 64'd1,           lat: 4'd1, rdly: 4'd0, restart: 1'b0, early: 1'b0},
    '{base: 8'd10,  cnt: 64'd3,           lat: 4'd2, rdly: 4'd2, restart: 1'b1, early: 1'b0},
    '{base: 8'd40,  cnt: 64'd0,           lat: 4'd1, rdly: 4'd0, restart: 1'b0, early: 1'b0},
    '{base: 8'd50,  cnt: 64'd2,           lat: 4'd3, rdly: 4'd1, restart: 1'b0, early: 1'b1},
    '{base: 8'd100, cnt: 64'h1_0000_0002, lat: 4'd1, rdly: 4'd0, restart: 1'b0, early: 1'b0}
  };

  task automatic run_list(input vec_t v);
    int  n = int'(v.cnt[31:0]);
    int  k = 0;
    int  guard = 0;
    bit  fin = 0;
    bit  seq_ok = 1;
    int  bad = 0;
    for (int a = 0; a < 256; a++) mem[a] = pat(a);
    mem[v.base] = v.cnt;
    lat = int'(v.lat);
    req_idx = 0;
    list_base = 32'(v.base);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (v.restart) begin
      repeat (3) @(negedge clk);
      list_base = 32'd200;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!fin && guard < 3000) begin
      guard++;
      if (done) begin
        fin = 1;
      end else if (desc_valid) begin
        // R8: next descriptor only after the previous access completed
        chk(req_idx == 1 + 9*(k+1), "R8 reads before offer", 64'(req_idx), 64'(1 + 9*(k+1)));
        if (v.early) begin
          access_done = 1'b1;
          @(negedge clk);
          access_done = 1'b0;
          @(negedge clk);
          chk(desc_valid == 1'b1, "R8 early access_done ignored", 64'(desc_valid), 64'd1);
        end
        for (int w = 0; w < int'(v.rdly); w++) @(negedge clk);
        chk(desc_valid == 1'b1, "R7 valid held", 64'(desc_valid), 64'd1);
        bad = -1;
        for (int j = 0; j < 9; j++) begin
          logic [63:0] got;
          if (j == 0) got = desc_base;
          else if (j % 2 == 1) got = desc_stride[((j-1)/2)*64 +: 64];
          else got = desc_size[((j-2)/2)*64 +: 64];
          if (got != pat(int'(v.base) + 1 + 9*k + j) && bad < 0) bad = j;
        end
        chk(bad < 0, "R6 descriptor fields", 64'(bad), 64'hFFFF_FFFF_FFFF_FFFF);
        desc_ready = 1'b1;
        @(negedge clk);
        desc_ready = 1'b0;
        repeat (3) @(negedge clk);
        chk(req_idx == 1 + 9*(k+1) && !desc_valid, "R8 paced on access_done",
            64'(req_idx), 64'(1 + 9*(k+1)));
        access_done = 1'b1;
        @(negedge clk);
        access_done = 1'b0;
        k++;
      end else begin
        @(negedge clk);
      end
    end
    chk(fin, "R9 done seen", 64'(fin), 64'd1);
    chk(k == n, (n == 0) ? "R10 no descriptor on zero count" : "R9 R11 descriptor count",
        64'(k), 64'(n));
    @(negedge clk);
    chk(!done, "R9 done one cycle", 64'(done), 64'd0);
    chk(req_idx == 1 + 9*n, "R4 R10 read count", 64'(req_idx), 64'(1 + 9*n));
    for (int j = 0; j < req_idx && j < 64; j++)
      if (req_log[j] != 32'(v.base) + 32'(j)) seq_ok = 0;
    chk(seq_ok, v.restart ? "R3 R2 R4 address sequence" : "R2 R4 address sequence",
        64'(seq_ok), 64'd1);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!mem_req && !desc_valid && !done, "R1 in reset", {61'd0, mem_req, desc_valid, done}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!mem_req && !desc_valid && !done, "R1 after reset", {61'd0, mem_req, desc_valid, done}, 64'd0);
    repeat (2) @(negedge clk);

    for (int i = 0; i < 5; i++) run_list(VEC[i]);

    // R1: reset in the middle of a list abandons it
    for (int a = 0; a < 256; a++) mem[a] = pat(a);
    mem[0] = 64'd2;
    lat = 1;
    list_base = 32'd0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!mem_req && !desc_valid && !done, "R1 mid-list reset", {61'd0, mem_req, desc_valid, done}, 64'd0);
    rst_n = 1'b1;
    req_idx = 0;
    repeat (20) @(negedge clk);
    chk(req_idx == 0 && !desc_valid && !done, "R1 idle after reset", 64'(req_idx), 64'd0);

    // Run after the abandoned list still works from a fresh base
    run_list('{base: 8'd20, cnt: 64'd1, lat: 4'd2, rdly: 4'd0, restart: 1'b0, early: 1'b0});

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule